// File: doc/BRIEF.md
# Burst Serial Sample Streamer

This transmit-only serial port sends a block of 32-bit sample words once per sample-rate tick. When a tick arrives, the block copies the chosen group of words into an internal frame image. It then shifts that image out on a data line, together with a serial clock that it generates and a framing strobe. Because the words are copied at the tick, the sample sources may change their values while a burst is in progress without affecting it.

Five configuration inputs control the port. They set the serial clock rate (fast or half speed), whether idle gaps go between transfer units, and whether a unit is a 32-bit word or an 8-bit byte. They also pick which group of words is sent and the active level of the strobe. At each tick the block counts the serial clock cycles the requested burst will take and compares that count with the length of one sample period. If the burst does not fit, the block transmits on that tick and ignores the next accepted tick, which halves the output rate.

Top module: `burst_sample_streamer`

## Requirements
- R1: A burst sends the selected words in increasing index order. Each word goes out most-significant bit first, one bit per serial cycle, and `sd_o` holds each bit for its whole serial cycle.
- R2: With `gap_i`=1, exactly 7 serial cycles separate consecutive transfer units. During those cycles `sclk_o` keeps toggling and `sd_o` is 0. No gap follows the last unit.
- R3: With `gap_i`=0, `byte_i` has no effect and the whole burst is one continuous bit stream with no idle cycles.
- R4: With `gap_i`=1 and `byte_i`=1, a unit is 8 bits, so the 7-cycle gap follows every byte. With `byte_i`=0, a unit is one 32-bit word.
- R5: `wset_i` code 0 sends words 0..15, code 1 sends words 0..6, and code 2 sends words 7..15. Code 3 sends nothing and clears any pending skip. Word j sits at `words_i[32*j+31:32*j]`.
- R6: One serial cycle lasts 2*HALF_FAST clocks with `slow_i`=0 and 4*HALF_FAST clocks with `slow_i`=1. `sclk_o` is low for the first half of each cycle and high for the second half. `sclk_o` is low while idle.
- R7: The burst length in serial cycles is computed from the configuration at the tick. If it exceeds PERIOD_FAST (fast clock) or PERIOD_FAST/2 (slow clock), the next accepted tick is ignored.
- R8: With `pol_i`=1 the strobe is high during a burst, gap cycles included, and low while idle. With `pol_i`=0 these levels are swapped.
- R9: The data sent is the value of `words_i` at the tick edge that starts the burst. Later changes to `words_i` do not affect the burst.
- R10: After reset the block is idle: `sclk_o`=0, `sd_o`=0, the strobe is inactive, and no skip is pending.
- R11: A tick that arrives while a burst is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-clock sample-rate tick |
| words_i | input | 512 | Sixteen 32-bit sample words, word j at bits 32*j+31:32*j |
| slow_i | input | 1 | 1 selects the half-speed serial clock |
| gap_i | input | 1 | 1 inserts 7 idle serial cycles between units |
| byte_i | input | 1 | 1 makes a unit 8 bits (used only when gaps are on) |
| wset_i | input | 2 | Word group selector |
| pol_i | input | 1 | Strobe active level |
| sclk_o | output | 1 | Serial clock |
| sd_o | output | 1 | Serial data |
| strobe_o | output | 1 | Framing strobe |

## Verification
The assertions assume that `pol_i` is steady throughout a burst and that `tick_i` lasts one clock. With those inputs, the strobe level is always a direct image of the busy state. The stimulus changes configuration and polarity only between scenarios, and only after the previous burst has drained. Words and extra ticks, by contrast, are driven deliberately in the middle of a burst, so the snapshot and busy-tick rules are exercised. The tick spacing is always a full sample period.

// File: rtl/bss_pkg.sv
package bss_pkg;

    localparam int WORD_W  = 32;
    localparam int SLOTS   = 16;
    localparam int BYTE_W  = 8;
    localparam int GAP_CYC = 7;
    localparam int IMG_W   = WORD_W * SLOTS;

    typedef enum logic [1:0] {
        SET_ALL  = 2'd0,
        SET_LOW  = 2'd1,
        SET_HIGH = 2'd2,
        SET_NONE = 2'd3
    } wset_e;

    typedef struct packed {
        logic  slow;
        logic  gap_en;
        logic  byte_units;
        wset_e wset;
    } cfg_t;

    function automatic logic [4:0] set_count(wset_e s);
        case (s)
            SET_ALL:  return 5'd16;
            SET_LOW:  return 5'd7;
            SET_HIGH: return 5'd9;
            default:  return 5'd0;
        endcase
    endfunction

    function automatic logic [3:0] set_base(wset_e s);
        return (s == SET_HIGH) ? 4'd7 : 4'd0;
    endfunction

    function automatic int burst_cycles(cfg_t c);
        int n;
        n = int'(set_count(c.wset));
        if (!c.gap_en)
            return WORD_W * n;
        if (c.byte_units)
            return WORD_W * n + GAP_CYC * (n * (WORD_W / BYTE_W) - 1);
        return WORD_W * n + GAP_CYC * (n - 1);
    endfunction

endpackage

// File: rtl/bss_divider.sv
module bss_divider #(
    parameter int HALF_FAST = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic slow,
    output logic sclk_ph,
    output logic cyc_end
);
    localparam int LIM = 4 * HALF_FAST - 1;
    localparam int CW  = $clog2(LIM + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim_sel;
    logic [CW-1:0] hi_sel;

    assign lim_sel = slow ? CW'(4 * HALF_FAST - 1) : CW'(2 * HALF_FAST - 1);
    assign hi_sel  = slow ? CW'(2 * HALF_FAST)     : CW'(HALF_FAST);
    assign cyc_end = run && (cnt == lim_sel);
    assign sclk_ph = run && (cnt >= hi_sel);

    always_ff @(posedge clk) begin
        if (rst || !run || cyc_end)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/bss_sequencer.sv
module bss_sequencer
    import bss_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [4:0] nwords,
    input  logic       gap_en,
    input  logic       byte_units,
    input  logic       cyc_end,
    output logic       busy,
    output logic       in_gap,
    output logic [2:0] gap_cnt,
    output logic       shift_en
);
    logic [4:0] bit_cnt;
    logic [4:0] bits_last;
    logic [5:0] unit_cnt;
    logic [5:0] units_last;
    logic       gap_q;
    logic [6:0] units_new;

    assign units_new = (gap_en && byte_units) ? {nwords, 2'b00} : {2'b00, nwords};
    assign shift_en  = busy && cyc_end && !in_gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            in_gap     <= 1'b0;
            gap_cnt    <= '0;
            bit_cnt    <= '0;
            unit_cnt   <= '0;
            bits_last  <= 5'd31;
            units_last <= '0;
            gap_q      <= 1'b0;
        end else if (start) begin
            busy       <= 1'b1;
            in_gap     <= 1'b0;
            gap_cnt    <= '0;
            bit_cnt    <= '0;
            unit_cnt   <= '0;
            gap_q      <= gap_en;
            bits_last  <= (gap_en && byte_units) ? 5'(BYTE_W - 1) : 5'(WORD_W - 1);
            units_last <= 6'(units_new - 7'd1);
        end else if (busy && cyc_end) begin
            if (in_gap) begin
                if (gap_cnt == 3'(GAP_CYC - 1)) begin
                    in_gap  <= 1'b0;
                    gap_cnt <= '0;
                end else begin
                    gap_cnt <= gap_cnt + 1'b1;
                end
            end else if (bit_cnt == bits_last) begin
                bit_cnt <= '0;
                if (unit_cnt == units_last) begin
                    busy <= 1'b0;
                end else begin
                    unit_cnt <= unit_cnt + 1'b1;
                    in_gap   <= gap_q;
                end
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bss_snapshot.sv
module bss_snapshot
    import bss_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             shift,
    input  wset_e            wset,
    input  logic [IMG_W-1:0] words_i,
    output logic             msb
);
    logic [IMG_W-1:0] img;
    logic [IMG_W-1:0] img_new;
    logic [4:0]       cnt;
    logic [3:0]       base;

    assign cnt  = set_count(wset);
    assign base = set_base(wset);
    assign msb  = img[IMG_W-1];

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        logic [3:0] idx;
        assign idx = base + 4'(k);
        assign img_new[IMG_W-1-k*WORD_W -: WORD_W] =
            (5'(k) < cnt) ? words_i[idx*WORD_W +: WORD_W] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            img <= '0;
        else if (load)
            img <= img_new;
        else if (shift)
            img <= {img[IMG_W-2:0], 1'b0};
    end
endmodule

// File: rtl/burst_sample_streamer.sv
module burst_sample_streamer
    import bss_pkg::*;
#(
    parameter int HALF_FAST   = 1,
    parameter int PERIOD_FAST = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [IMG_W-1:0] words_i,
    input  logic             slow_i,
    input  logic             gap_i,
    input  logic             byte_i,
    input  logic [1:0]       wset_i,
    input  logic             pol_i,
    output logic             sclk_o,
    output logic             sd_o,
    output logic             strobe_o
);
    localparam int PERIOD_SLOW = PERIOD_FAST / 2;

    cfg_t       cfg_in;
    logic       busy, in_gap, cyc_end, sclk_ph, msb, shift_en;
    logic       skip_q, slow_q, gap_en_q;
    logic [2:0] gap_cnt;
    logic       accept, valid, start, over_budget;

    assign cfg_in      = '{slow: slow_i, gap_en: gap_i, byte_units: byte_i, wset: wset_e'(wset_i)};
    assign accept      = tick_i && !busy;
    assign valid       = (cfg_in.wset != SET_NONE);
    assign start       = accept && !skip_q && valid;
    assign over_budget = burst_cycles(cfg_in) > (cfg_in.slow ? PERIOD_SLOW : PERIOD_FAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            skip_q   <= 1'b0;
            slow_q   <= 1'b0;
            gap_en_q <= 1'b0;
        end else begin
            if (accept)
                skip_q <= start && over_budget;
            if (start) begin
                slow_q   <= cfg_in.slow;
                gap_en_q <= cfg_in.gap_en;
            end
        end
    end

    bss_divider #(.HALF_FAST(HALF_FAST)) u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .slow    (slow_q),
        .sclk_ph (sclk_ph),
        .cyc_end (cyc_end)
    );

    bss_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .nwords     (set_count(cfg_in.wset)),
        .gap_en     (cfg_in.gap_en),
        .byte_units (cfg_in.byte_units),
        .cyc_end    (cyc_end),
        .busy       (busy),
        .in_gap     (in_gap),
        .gap_cnt    (gap_cnt),
        .shift_en   (shift_en)
    );

    bss_snapshot u_snap (
        .clk     (clk),
        .rst     (rst),
        .load    (start),
        .shift   (shift_en),
        .wset    (cfg_in.wset),
        .words_i (words_i),
        .msb     (msb)
    );

    assign sclk_o   = sclk_ph;
    assign sd_o     = busy && !in_gap && msb;
    assign strobe_o = pol_i ? busy : !busy;
endmodule

// File: rtl/bss_checker.sv
module bss_checker (
    input logic       clk,
    input logic       rst,
    input logic       tick_i,
    input logic       pol_i,
    input logic       sclk_o,
    input logic       sd_o,
    input logic       strobe_o,
    input logic       busy,
    input logic       in_gap,
    input logic [2:0] gap_cnt,
    input logic       skip_q,
    input logic       gap_en_q
);
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (strobe_o != pol_i) |-> (!sclk_o && !sd_o));

    p_gap_data_low_r2: assert property (@(posedge clk) disable iff (rst)
        in_gap |-> !sd_o);

    p_gap_bound_r2: assert property (@(posedge clk) disable iff (rst)
        in_gap |-> (gap_cnt < 3'd7));

    p_no_gap_when_off_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && !gap_en_q) |-> !in_gap);

    p_sclk_in_burst_r6: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> busy);

    p_strobe_level_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> (strobe_o == pol_i));

    p_skip_tick_r7: assert property (@(posedge clk) disable iff (rst)
        (skip_q && tick_i && !busy) |=> (!busy && !skip_q));

    p_start_on_tick_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(tick_i));
endmodule

bind burst_sample_streamer bss_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick_i),
    .pol_i    (pol_i),
    .sclk_o   (sclk_o),
    .sd_o     (sd_o),
    .strobe_o (strobe_o),
    .busy     (busy),
    .in_gap   (in_gap),
    .gap_cnt  (gap_cnt),
    .skip_q   (skip_q),
    .gap_en_q (gap_en_q)
);

// File: tb/burst_sample_streamer_tb.sv
module burst_sample_streamer_tb;
    localparam int HALF    = 1;
    localparam int PERIOD  = 1000;
    localparam int SPACING = PERIOD * 2 * HALF;
    localparam int WDOG    = 190000;

    logic         clk = 0;
    logic         rst = 1;
    logic         tick = 0;
    logic [511:0] words = '0;
    logic         slow = 0, gap = 0, bytem = 0, pol = 1;
    logic [1:0]   wset = 0;
    logic         sclk, sd, strobe;

    int  tests = 0, fails = 0, cyc = 0, bursts = 0;
    bit  running = 0, prev_act = 0;
    string tag = "R1";

    logic         tick_e, slow_e, gap_e, byte_e;
    logic [1:0]   wset_e;
    logic [511:0] words_e;

    logic [1:0] q[$];
    int  pos = 0, per = 2;
    bit  m_busy = 0, m_skip = 0;

    always #5 clk = ~clk;

    burst_sample_streamer #(.HALF_FAST(HALF), .PERIOD_FAST(PERIOD)) u_dut (
        .clk(clk), .rst(rst), .tick_i(tick), .words_i(words),
        .slow_i(slow), .gap_i(gap), .byte_i(bytem), .wset_i(wset), .pol_i(pol),
        .sclk_o(sclk), .sd_o(sd), .strobe_o(strobe)
    );

    always @(posedge clk) begin
        tick_e  <= tick;
        slow_e  <= slow;
        gap_e   <= gap;
        byte_e  <= bytem;
        wset_e  <= wset;
        words_e <= words;
        cyc     <= cyc + 1;
    end

    task automatic check(input string req, input logic act, input logic exp, input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, cyc, act, exp);
        end
    endtask

    task automatic build();
        int n, base, ulen, cnt;
        q.delete();
        case (wset_e)
            2'd0: begin n = 16; base = 0; end
            2'd1: begin n = 7;  base = 0; end
            default: begin n = 9; base = 7; end
        endcase
        ulen = gap_e ? (byte_e ? 8 : 32) : 32 * n;
        cnt = 0;
        for (int w = 0; w < n; w++)
            for (int b = 31; b >= 0; b--) begin
                q.push_back({1'b0, words_e[(base + w) * 32 + b]});
                cnt++;
                if (gap_e && (cnt % ulen == 0) && cnt < 32 * n)
                    for (int g = 0; g < 7; g++) q.push_back(2'b10);
            end
    endtask

    // reference model, compared on every clock at the falling edge
    always @(negedge clk) begin
        if (running && !rst) begin
            bit was;
            bit act;
            logic e_sclk, e_sd, e_gap;
            was = m_busy;
            if (m_busy) begin
                pos++;
                if (pos == q.size() * per) m_busy = 0;
            end
            if (tick_e && !was) begin
                if (m_skip) m_skip = 0;
                else if (wset_e == 2'd3) m_skip = 0;
                else begin
                    build();
                    per    = slow_e ? 4 * HALF : 2 * HALF;
                    pos    = 0;
                    m_busy = 1;
                    m_skip = q.size() > (slow_e ? PERIOD / 2 : PERIOD);
                end
            end
            e_gap  = m_busy ? q[pos / per][1] : 1'b0;
            e_sd   = m_busy ? q[pos / per][0] : 1'b0;
            e_sclk = m_busy && ((pos % per) >= per / 2);
            check("R6", sclk, e_sclk, "sclk");
            check("R8", strobe, m_busy ? pol : !pol, "strobe");
            check(e_gap ? "R2" : tag, sd, e_sd, "data");
            act = (strobe == pol);
            if (act && !prev_act) bursts++;
            prev_act = act;
        end
    end

    always @(posedge clk) begin
        if (cyc == WDOG) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired: actual %0d expected < %0d cycles", cyc, WDOG);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic new_words();
        for (int j = 0; j < 16; j++) words[j * 32 +: 32] = $urandom;
    endtask

    task automatic pulse_tick();
        @(posedge clk); #2 tick = 1;
        @(posedge clk); #2 tick = 0;
    endtask

    task automatic run_case(input logic s, input logic g, input logic b, input logic [1:0] ws,
                            input logic p, input int nt, input int exp_b, input string t,
                            input bit extra);
        int b0;
        @(posedge clk); #2;
        slow = s; gap = g; bytem = b; wset = ws; pol = p; tag = t;
        repeat (20) @(posedge clk);
        b0 = bursts;
        for (int i = 0; i < nt; i++) begin
            new_words();
            pulse_tick();
            repeat (40) @(posedge clk);
            #2 new_words();          // R9: change words mid-burst
            if (extra) begin
                repeat (30) @(posedge clk);
                pulse_tick();        // R11: tick while busy
                repeat (SPACING - 74) @(posedge clk);
            end else begin
                repeat (SPACING - 42) @(posedge clk);
            end
        end
        repeat (2 * SPACING) @(posedge clk);
        tests++;
        if (bursts - b0 != exp_b) begin
            fails++;
            $display("FAIL %s burst count: actual %0d expected %0d", t, bursts - b0, exp_b);
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #2 rst = 0;
        @(negedge clk);
        check("R10", sclk, 1'b0, "reset sclk");
        check("R10", sd, 1'b0, "reset data");
        check("R10", strobe, !pol, "reset strobe");
        running = 1;
        run_case(0, 0, 0, 2'd0, 1, 2, 2, "R9",  0);
        run_case(0, 0, 0, 2'd1, 1, 2, 2, "R1",  0);
        run_case(0, 1, 0, 2'd1, 1, 2, 2, "R2",  0);
        run_case(0, 0, 1, 2'd2, 1, 2, 2, "R3",  0);
        run_case(0, 1, 1, 2'd2, 1, 2, 2, "R4",  0);
        run_case(0, 1, 1, 2'd0, 0, 2, 2, "R8",  0);
        run_case(1, 0, 0, 2'd1, 1, 2, 2, "R6",  0);
        run_case(1, 0, 0, 2'd0, 1, 4, 2, "R7",  0);
        run_case(1, 1, 1, 2'd0, 1, 2, 1, "R7",  0);
        run_case(0, 0, 0, 2'd3, 1, 2, 0, "R5",  0);
        run_case(0, 1, 0, 2'd0, 1, 2, 2, "R11", 1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule